// File: doc/BRIEF.md
# Multi-lane Match Tally

This block keeps a running total of pattern hits reported by several detector lanes that all work on the same clock. Each lane raises a one-bit hit flag in any cycle where it has seen a match. Several lanes may flag in the same cycle, and every one of those flags adds to the total, so no simultaneous match is lost. A plain OR of the lanes would record such a cycle as a single hit.

The lane flags pass through a purely combinational population-count encoder. Its result is an increment of 0 to 4 that feeds an 8-bit counter in the same cycle. The counter can also be cleared through the synchronous active-low reset, or preset from a load value. Clear takes priority over load, and load takes priority over counting. A surrounding packet engine typically presets or clears the total at the start of a packet and reads `count` once the packet is done.

Top module: `match_tally`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` is 0 after that edge, whatever `load_en`, `load_val` and `lane_hit` are.
- R2: When `rst_n` is high and `load_en` is high at a rising edge, `count` equals `load_val` after that edge, and `lane_hit` has no effect in that cycle.
- R3: When `rst_n` is high and `load_en` is low, each edge adds to `count` the number of set bits in `lane_hit`, for every one of the 16 patterns of the 4-bit vector. Bit i of the vector is lane i. All four set adds 4, any three add 3, any two add 2 and any one adds 1.
- R4: When `rst_n` is high, `load_en` is low and `lane_hit` is 4'b0000, `count` holds its value across the edge.
- R5: `count` is 8 bits wide and wraps modulo 256. For example, 255 plus 1 gives 0 and 253 plus 4 gives 1.
- R6: The increment takes effect at the first rising edge after the flags are applied, with no extra pipeline cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear of the total |
| load_en | input | 1 | Preset the total from `load_val` |
| load_val | input | 8 | Preset value |
| lane_hit | input | 4 | Per-lane hit flags, bit i from lane i |
| count | output | 8 | Running total of hits |

## Verification
The embedded properties check on every cycle that a clear yields zero, that a preset yields the preset value, that a counting cycle advances the total by the popcount of the previous flags modulo 256, and that an idle cycle leaves the total unchanged. Only the bench scenarios can show some of the behaviour. These scenarios sweep all sixteen flag patterns from start values close to the wrap point, confirm that flags raised together with a preset or a clear leave no trace, and run a long accumulation that wraps several times against a total computed arithmetically.

// File: rtl/match_tally_pkg.sv
// Package: match_tally_pkg
// Shared types for the multi-lane match tally. It holds the operation that the
// control decoder selects for the counter register in each cycle.
package match_tally_pkg;

    // Counter operation, already resolved by priority
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_ADD   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } tally_op_e;

endpackage

// File: rtl/lane_popcount.sv
// Module: lane_popcount
// Counts how many lane flags are set in the current cycle and reports whether
// any flag is set at all. The module is purely combinational.
// Assumes: the AMT_W output is wide enough to hold LANES.
module lane_popcount #(
    parameter int LANES = 4,
    parameter int AMT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] lanes,
    output logic [AMT_W-1:0] amt,
    output logic             any_hit
);

    // Ripple of partial sums, one adder stage per lane
    logic [AMT_W-1:0] partial [LANES+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_sum
        assign partial[g+1] = partial[g] + AMT_W'(lanes[g]);
    end

    assign amt     = partial[LANES];
    assign any_hit = |lanes;

    // Purpose: the adder chain and the OR agree, and the sum stays in range (R3)
    always_comb begin
        if (!$isunknown(lanes)) begin
            a_r3_amt_matches_any: assert ((amt != '0) == any_hit);
            a_r3_amt_in_range:    assert (int'(amt) <= LANES);
        end
    end

endmodule

// File: rtl/tally_ctl.sv
// Module: tally_ctl
// Resolves the control inputs into one counter operation with a fixed
// priority: clear first, then load, then add. Add is chosen only when at
// least one lane is set, so an idle cycle becomes a hold.
// Assumes: rst_n is synchronous and active low.
module tally_ctl
    import match_tally_pkg::*;
(
    input  logic      rst_n,
    input  logic      load_en,
    input  logic      any_hit,
    output tally_op_e op
);

    // Purpose: priority decode of clear, load and add
    always_comb begin
        if (!rst_n) begin
            op = OP_CLEAR;
        end else if (load_en) begin
            op = OP_LOAD;
        end else if (any_hit) begin
            op = OP_ADD;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/tally_counter.sv
// Module: tally_counter
// The total register. It applies the operation chosen by tally_ctl. The add
// path zero-extends the lane popcount and wraps at the register width.
// Assumes: CNT_W > AMT_W.
module tally_counter
    import match_tally_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int AMT_W = 3
) (
    input  logic             clk,
    input  tally_op_e        op,
    input  logic [CNT_W-1:0] load_val,
    input  logic [AMT_W-1:0] amt,
    output logic [CNT_W-1:0] cnt_q
);

    localparam int PAD_W = CNT_W - AMT_W;

    logic [CNT_W-1:0] step;

    assign step = {{PAD_W{1'b0}}, amt};

    // Purpose: update the total from the resolved operation
    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: cnt_q <= '0;
            OP_LOAD:  cnt_q <= load_val;
            OP_ADD:   cnt_q <= cnt_q + step;
            default:  cnt_q <= cnt_q;
        endcase
    end

endmodule

// File: rtl/match_tally.sv
// Module: match_tally
// Top level of the multi-lane match tally. The lane flags feed a popcount
// encoder. The control decoder picks clear, load, add or hold, and the
// counter register holds the total. There is no register between the flags
// and the total.
// Assumes: rst_n is held low for at least one rising edge before use.
module match_tally
    import match_tally_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [LANES-1:0] lane_hit,
    output logic [CNT_W-1:0] count
);

    localparam int AMT_W = $clog2(LANES + 1);

    logic [AMT_W-1:0] amt;
    logic             any_hit;
    tally_op_e        op;

    lane_popcount #(.LANES(LANES), .AMT_W(AMT_W)) u_pop (
        .lanes   (lane_hit),
        .amt     (amt),
        .any_hit (any_hit)
    );

    tally_ctl u_ctl (
        .rst_n   (rst_n),
        .load_en (load_en),
        .any_hit (any_hit),
        .op      (op)
    );

    tally_counter #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_cnt (
        .clk      (clk),
        .op       (op),
        .load_val (load_val),
        .amt      (amt),
        .cnt_q    (count)
    );

    // R1: a clear edge leaves zero, whatever the other inputs are
    a_r1_clear_wins: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    // R2: a load edge leaves exactly the load value
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count == $past(load_val));

    // R3 R5 R6: a counting edge adds the popcount of the flags, modulo 2^CNT_W
    a_r3_adds_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> count == CNT_W'($past(count) + $countones($past(lane_hit))));

    // R4: an idle edge keeps the total
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && lane_hit == '0) |=> $stable(count));

endmodule

// File: tb/match_tally_tb_top.sv
// Bench for match_tally: it sweeps all flag patterns from several start values
// and computes every expected total arithmetically.
module match_tally_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic [3:0] lane_hit = 4'h0;
    logic [7:0] count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    match_tally dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .lane_hit (lane_hit),
        .count    (count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive at the falling edge, pass one rising edge, then settle before sampling
    task automatic cycle(input logic r, input logic ld, input logic [7:0] v,
                         input logic [3:0] h);
        @(negedge clk);
        rst_n = r;
        load_en = ld;
        load_val = v;
        lane_hit = h;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: count=%0d expected=completion", count);
        finish_run();
    end

    initial begin
        int starts [6] = '{0, 1, 100, 252, 253, 255};
        int exp_total;

        // R1: reset wins over a load and over all four flags
        cycle(1'b0, 1'b1, 8'hAA, 4'hF);
        cycle(1'b0, 1'b1, 8'hAA, 4'hF);
        check("R1 reset over load and hits", count, 8'd0);

        // R4: idle cycle after reset keeps zero
        cycle(1'b1, 1'b0, 8'h55, 4'h0);
        check("R4 idle after reset", count, 8'd0);

        // R2 R3 R5 R6 R4: every pattern from every start value
        foreach (starts[s]) begin
            for (int p = 0; p < 16; p++) begin
                // Load while flags are set: flags must leave no trace (R2)
                cycle(1'b1, 1'b1, 8'(starts[s]), 4'(p));
                check("R2 load ignores hits", count, 8'(starts[s]));
                // One counting edge: the popcount lands at once (R3, R6)
                cycle(1'b1, 1'b0, 8'h00, 4'(p));
                exp_total = (starts[s] + $countones(4'(p))) % 256;
                if (starts[s] + $countones(4'(p)) > 255)
                    check("R5 wrap on add", count, 8'(exp_total));
                else
                    check("R3 R6 popcount step", count, 8'(exp_total));
                // Idle edge holds the sum (R4)
                cycle(1'b1, 1'b0, 8'hFF, 4'h0);
                check("R4 hold when idle", count, 8'(exp_total));
            end
        end

        // R3 R5: long accumulation through several wraps
        cycle(1'b1, 1'b1, 8'd0, 4'h0);
        check("R2 preset zero", count, 8'd0);
        exp_total = 0;
        for (int c = 0; c < 300; c++) begin
            logic [3:0] pat;
            pat = 4'((c * 7 + 3) % 16);
            cycle(1'b1, 1'b0, 8'h00, pat);
            exp_total = (exp_total + $countones(pat)) % 256;
            check("R3 R5 accumulate", count, 8'(exp_total));
        end

        // R1: reset mid-run with load and flags active
        cycle(1'b0, 1'b1, 8'h77, 4'hF);
        check("R1 reset mid-run", count, 8'd0);

        // R5: exact wrap from 255 by one lane
        cycle(1'b1, 1'b1, 8'd255, 4'h0);
        cycle(1'b1, 1'b0, 8'd0, 4'b0100);
        check("R5 255 plus 1", count, 8'd0);

        finish_run();
    end

endmodule